// File: doc/BRIEF.md
# Four-Stage Accumulator Pipeline Core

This block is the control and datapath skeleton of a small in-order processor with four stages: instruction fetch into a prefetch queue, decode with effective-address formation, operand read, and execute-with-writeback. Program and data live in two separate internal arrays, both preset from parameters at reset. Instruction fetch therefore never competes with data access. The fetcher fills the queue whenever it has a free slot.

Two hazards are resolved in hardware without forwarding. A jump detected at decode stops the queue from feeding decode until the jump has executed. A taken jump empties the queue and moves the program counter in one cycle. A not-taken jump lets the already queued successor go on without being fetched again. A store in the execute stage owns the single data-memory port, so an operand read that collides with it waits one cycle and then sees the stored value. The accumulator, a retirement counter and a halt flag are brought out so that a surrounding bench or system can follow the program.

Top module: `pipe4_core`

## Requirements
- R1: While reset is held, acc_o, retired_o and halted_o are all zero. After release, fetching starts at program address 0 and the data array holds the DMEM_INIT image.
- R2: An instruction word has a 3-bit opcode in its upper bits above an AW-bit address field. The opcodes are 0 halt, 1 load (acc gets mem[addr]), 2 add (acc gets acc + mem[addr], modulo 2^DW), 3 store (mem[addr] gets acc), 4 jump, and 5 jump-if-zero (taken when acc is zero). Instructions retire in program order with these effects.
- R3: The first instruction retires on the 5th rising edge after reset release. With no hazard, one instruction retires on every edge after that.
- R4: When the execute stage holds a store and the operand stage holds a load or add, the operand stage holds its instruction for one cycle and inserts a bubble. It then reads the freshly stored value.
- R5: From the cycle a jump sits in decode until the cycle it executes, the queue hands nothing to decode. After a not-taken jump, the queued successor retires 4 edges after the jump, with no refetch.
- R6: When a jump is taken in execute, the queue is emptied and the program counter is loaded with the target in that same cycle. The target instruction retires 5 edges after the jump. Instructions queued behind the jump never take effect.
- R7: halted_o rises on the edge on which a halt retires. From then on, acc_o and retired_o never change.
- R8: retired_o rises by exactly one for every retired instruction, including the halt.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_o | output | DW | Accumulator value |
| retired_o | output | CW | Number of retired instructions |
| halted_o | output | 1 | Set once a halt instruction has retired |

## Verification
Two collisions can fall into one cycle. A store in execute can meet an operand read of the very address it writes. A jump can be held in the operand stage while the queue is full. The test program stores a value and reads it back in the next instruction, twice. It also places a not-taken and a taken conditional jump and an unconditional jump behind full queues. Each case is judged by the accumulator value at every retirement and by the clock edge on which that retirement falls; both are worked out beforehand from the stage counts.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_HLT  = 3'd0,
        OP_LDA  = 3'd1,
        OP_ADD  = 3'd2,
        OP_STA  = 3'd3,
        OP_JMP  = 3'd4,
        OP_JZ   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    function automatic logic op_is_jump(op_e op);
        return (op == OP_JMP) || (op == OP_JZ);
    endfunction

    function automatic logic op_reads_mem(op_e op);
        return (op == OP_LDA) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/pipe4_imem.sv
module pipe4_imem #(
    parameter int AW = 4,
    parameter int IW = 7,
    parameter logic [(2**AW)*IW-1:0] INIT = '0
) (
    input  logic [AW-1:0] addr_i,
    output logic [IW-1:0] word_o
);

    localparam int WORDS = 2**AW;

    logic [WORDS-1:0][IW-1:0] rom;

    assign rom    = INIT;
    assign word_o = rom[addr_i];

endmodule

// File: rtl/pipe4_dmem.sv
module pipe4_dmem #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter logic [(2**AW)*DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i
);

    localparam int WORDS = 2**AW;

    logic [WORDS-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= INIT;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/pipe4_prefetch.sv
module pipe4_prefetch #(
    parameter int AW    = 4,
    parameter int IW    = 7,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         freeze_i,
    input  logic                         flush_i,
    input  logic [AW-1:0]                target_i,
    input  logic                         pop_i,
    output logic [AW-1:0]                fetch_addr_o,
    input  logic [IW-1:0]                fetch_word_i,
    output logic [IW-1:0]                head_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0]                pc;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CNTW-1:0]              cnt;
        logic [DEPTH-1:0][IW-1:0]     slot;
    } pf_t;

    pf_t q, n;
    logic full, push, take;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        n    = q;
        full = (q.cnt == CNTW'(DEPTH));
        push = !freeze_i && !flush_i && !full;
        take = pop_i && (q.cnt != '0) && !flush_i;
        if (flush_i) begin
            n.pc  = target_i;
            n.rd  = '0;
            n.wr  = '0;
            n.cnt = '0;
        end else begin
            if (push) begin
                n.slot[q.wr] = fetch_word_i;
                n.wr         = step(q.wr);
                n.pc         = q.pc + AW'(1);
            end
            if (take) begin
                n.rd = step(q.rd);
            end
            n.cnt = q.cnt + CNTW'(push) - CNTW'(take);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign fetch_addr_o = q.pc;
    assign head_o       = q.slot[q.rd];
    assign empty_o      = (q.cnt == '0);
    assign count_o      = q.cnt;

endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
    import pipe4_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int QDEPTH = 4,
    parameter int CW     = 16,
    parameter logic [(2**AW)*(OPW+AW)-1:0] IMEM_INIT = '0,
    parameter logic [(2**AW)*DW-1:0]       DMEM_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] acc_o,
    output logic [CW-1:0] retired_o,
    output logic          halted_o
);

    localparam int IW   = OPW + AW;
    localparam int CNTW = $clog2(QDEPTH+1);

    typedef struct packed {
        logic          v;
        op_e           op;
        logic [AW-1:0] ea;
    } opstg_t;

    typedef struct packed {
        logic          v;
        op_e           op;
        logic [AW-1:0] ea;
        logic [DW-1:0] opnd;
    } exstg_t;

    typedef struct packed {
        logic          da_v;
        logic [IW-1:0] da_w;
        opstg_t        fo;
        exstg_t        ex;
        logic [DW-1:0] acc;
        logic [CW-1:0] rcnt;
        logic          halted;
    } core_t;

    core_t q, n;

    logic [AW-1:0]   if_addr;
    logic [IW-1:0]   if_word;
    logic [IW-1:0]   q_head;
    logic            q_empty;
    logic [CNTW-1:0] q_count;
    logic [DW-1:0]   rd_data;

    logic ex_live, taken, st_en, fo_stall, fo_free;
    logic da_move, da_free, br_pend, pop;
    op_e  da_op;

    pipe4_imem #(.AW(AW), .IW(IW), .INIT(IMEM_INIT)) u_imem (
        .addr_i (if_addr),
        .word_o (if_word)
    );

    pipe4_prefetch #(.AW(AW), .IW(IW), .DEPTH(QDEPTH)) u_pf (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze_i     (q.halted),
        .flush_i      (taken),
        .target_i     (q.ex.ea),
        .pop_i        (pop),
        .fetch_addr_o (if_addr),
        .fetch_word_i (if_word),
        .head_o       (q_head),
        .empty_o      (q_empty),
        .count_o      (q_count)
    );

    pipe4_dmem #(.AW(AW), .DW(DW), .INIT(DMEM_INIT)) u_dmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (q.fo.ea),
        .rd_data_o (rd_data),
        .wr_en_i   (st_en),
        .wr_addr_i (q.ex.ea),
        .wr_data_i (q.acc)
    );

    always_comb begin
        n        = q;
        da_op    = op_e'(q.da_w[IW-1 -: OPW]);
        ex_live  = q.ex.v && !q.halted;
        taken    = ex_live && ((q.ex.op == OP_JMP) ||
                               ((q.ex.op == OP_JZ) && (q.acc == '0)));
        st_en    = ex_live && (q.ex.op == OP_STA);
        fo_stall = q.fo.v && op_reads_mem(q.fo.op) && st_en;
        fo_free  = !q.fo.v || !fo_stall;
        da_move  = q.da_v && fo_free;
        da_free  = !q.da_v || da_move;
        br_pend  = (q.da_v && op_is_jump(da_op)) ||
                   (q.fo.v && op_is_jump(q.fo.op)) ||
                   (q.ex.v && op_is_jump(q.ex.op));
        pop      = !q.halted && da_free && !q_empty && !br_pend;

        if (!q.halted) begin
            // execute and write back
            if (ex_live) begin
                case (q.ex.op)
                    OP_LDA:  n.acc    = q.ex.opnd;
                    OP_ADD:  n.acc    = q.acc + q.ex.opnd;
                    OP_HLT:  n.halted = 1'b1;
                    default: n.acc    = q.acc;
                endcase
                n.rcnt = q.rcnt + CW'(1);
            end
            // operand fetch into execute
            n.ex.v    = q.fo.v && !fo_stall;
            n.ex.op   = q.fo.op;
            n.ex.ea   = q.fo.ea;
            n.ex.opnd = rd_data;
            // decode and address into operand fetch
            if (da_move) begin
                n.fo.v  = 1'b1;
                n.fo.op = da_op;
                n.fo.ea = q.da_w[AW-1:0];
            end else if (!fo_stall) begin
                n.fo.v  = 1'b0;
            end
            // queue head into decode
            if (pop) begin
                n.da_v = 1'b1;
                n.da_w = q_head;
            end else if (da_move) begin
                n.da_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign acc_o     = q.acc;
    assign retired_o = q.rcnt;
    assign halted_o  = q.halted;

endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk
    import pipe4_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int QDEPTH = 4,
    parameter int CW     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        halted,
    input logic [CW-1:0]               rcnt,
    input logic [DW-1:0]               acc,
    input logic                        ex_v,
    input logic [OPW-1:0]              ex_op,
    input logic [AW-1:0]               ex_ea,
    input logic                        fo_v,
    input logic [OPW-1:0]              fo_op,
    input logic [AW-1:0]               fo_ea,
    input logic [$clog2(QDEPTH+1)-1:0] fifo_cnt,
    input logic [AW-1:0]               pc
);

    logic ex_store, fo_read, fo_jump, ex_taken;

    assign ex_store = ex_v && (ex_op == OP_STA);
    assign fo_read  = fo_v && ((fo_op == OP_LDA) || (fo_op == OP_ADD));
    assign fo_jump  = fo_v && ((fo_op == OP_JMP) || (fo_op == OP_JZ));
    assign ex_taken = ex_v && ((ex_op == OP_JMP) || ((ex_op == OP_JZ) && (acc == '0)));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_frozen_after_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(rcnt) && $stable(acc)));

    assert_retire_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> ((rcnt == $past(rcnt)) || (rcnt == $past(rcnt) + CW'(1))));

    assert_store_holds_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && ex_store && fo_read) |=>
            (fo_v && (fo_op == $past(fo_op)) && (fo_ea == $past(fo_ea))));

    assert_jump_blocks_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && fo_jump) |=> (fifo_cnt >= $past(fifo_cnt)));

    assert_taken_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && ex_taken) |=> ((fifo_cnt == '0) && (pc == $past(ex_ea))));

endmodule

bind pipe4_core pipe4_core_chk #(
    .AW(AW), .DW(DW), .QDEPTH(QDEPTH), .CW(CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halted   (q.halted),
    .rcnt     (q.rcnt),
    .acc      (q.acc),
    .ex_v     (q.ex.v),
    .ex_op    (q.ex.op),
    .ex_ea    (q.ex.ea),
    .fo_v     (q.fo.v),
    .fo_op    (q.fo.op),
    .fo_ea    (q.fo.ea),
    .fifo_cnt (q_count),
    .pc       (if_addr)
);

// File: tb/pipe4_core_test.sv
module pipe4_core_test;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int QD = 4;
    localparam int CW = 16;

    // program, address 15 down to 0: {opcode, address}
    localparam logic [16*7-1:0] PROG = {
        {3'd0, 4'd0},   // 15 halt
        {3'd0, 4'd0},   // 14 halt
        {3'd0, 4'd0},   // 13 halt
        {3'd1, 4'd13},  // 12 load 13   (store-read collision)
        {3'd3, 4'd13},  // 11 store 13
        {3'd1, 4'd8},   // 10 load 8    (must be discarded)
        {3'd4, 4'd11},  // 9  jump 11
        {3'd2, 4'd9},   // 8  add 9
        {3'd2, 4'd8},   // 7  add 8     (must be discarded)
        {3'd5, 4'd8},   // 6  jump-if-zero 8 (taken)
        {3'd1, 4'd10},  // 5  load 10   (value 0)
        {3'd5, 4'd7},   // 4  jump-if-zero 7 (not taken)
        {3'd2, 4'd12},  // 3  add 12    (store-read collision)
        {3'd3, 4'd12},  // 2  store 12
        {3'd2, 4'd9},   // 1  add 9
        {3'd1, 4'd8}    // 0  load 8
    };

    // data words 15..8 then 7..0: mem[9]=3, mem[8]=5
    localparam logic [16*8-1:0] DATA = {48'd0, 8'd3, 8'd5, 64'd0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] acc_o;
    logic [CW-1:0] retired_o;
    logic          halted_o;

    pipe4_core #(
        .AW(AW), .DW(DW), .QDEPTH(QD), .CW(CW),
        .IMEM_INIT(PROG), .DMEM_INIT(DATA)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_o     (acc_o),
        .retired_o (retired_o),
        .halted_o  (halted_o)
    );

    always #5ns clk = ~clk;   // 100 MHz

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    last_cnt = 0;
    int    halt_cyc = -1;
    bit    mon_on = 1'b0;
    int    exp_edge[$];
    int    exp_acc[$];
    string exp_req[$];

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_retire(input int edge_no, input int acc_val, input string req);
        exp_edge.push_back(edge_no);
        exp_acc.push_back(acc_val);
        exp_req.push_back(req);
    endtask

    // monitor: compare each retirement against the scoreboard
    always @(negedge clk) begin
        int    e_edge;
        int    e_acc;
        string e_req;
        if (mon_on) begin
            if (halted_o && halt_cyc < 0) halt_cyc = cyc;
            if (int'(retired_o) != last_cnt) begin
                check(int'(retired_o) == last_cnt + 1, "R8", "retire count step",
                      int'(retired_o), last_cnt + 1);
                if (exp_edge.size() == 0) begin
                    check(1'b0, "R7", "retirement after the last expected one",
                          int'(retired_o), 12);
                end else begin
                    e_edge = exp_edge.pop_front();
                    e_acc  = exp_acc.pop_front();
                    e_req  = exp_req.pop_front();
                    check(cyc == e_edge, e_req, "retire edge", cyc, e_edge);
                    check(int'(acc_o) == e_acc, e_req, "accumulator", int'(acc_o), e_acc);
                end
                last_cnt = int'(retired_o);
            end
        end
    end

    initial begin
        int guard;
        // driver: expected retirements (edge after release, accumulator)
        expect_retire(5,  5,  "R3");   // load 8
        expect_retire(6,  8,  "R3");   // add 9, back to back
        expect_retire(7,  8,  "R2");   // store 12
        expect_retire(9,  16, "R4");   // add 12 after one bubble
        expect_retire(10, 16, "R5");   // jump-if-zero not taken
        expect_retire(14, 0,  "R5");   // queued successor, no refetch
        expect_retire(15, 0,  "R6");   // jump-if-zero taken
        expect_retire(20, 3,  "R6");   // target add 9, add 8 discarded
        expect_retire(21, 3,  "R6");   // jump
        expect_retire(26, 3,  "R2");   // store 13, load 8 discarded
        expect_retire(28, 3,  "R4");   // load 13 after one bubble
        expect_retire(29, 3,  "R7");   // halt

        repeat (3) @(negedge clk);
        check(acc_o == '0,     "R1", "acc in reset",     int'(acc_o), 0);
        check(retired_o == '0, "R1", "count in reset",   int'(retired_o), 0);
        check(halted_o == 1'b0, "R1", "halted in reset", int'(halted_o), 0);

        rst_n  = 1'b1;
        mon_on = 1'b1;

        guard = 0;
        while (!halted_o && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        if (!halted_o) check(1'b0, "R7", "watchdog expired before halt", guard, 400);

        repeat (10) @(negedge clk);
        check(halt_cyc == 29,      "R7", "halt edge",           halt_cyc, 29);
        check(halted_o == 1'b1,    "R7", "halted stays set",    int'(halted_o), 1);
        check(int'(acc_o) == 3,    "R7", "acc frozen",          int'(acc_o), 3);
        check(int'(retired_o) == 12, "R8", "final count",       int'(retired_o), 12);
        check(exp_edge.size() == 0, "R2", "missing retirements", exp_edge.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule